// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block keeps the interrupt status and interrupt enable words of an Ethernet MAC. It drives one interrupt line for transmit and one for receive. The transmit and receive engines raise single-cycle event pulses, and each pulse latches a status bit. Software writes a mask to the status word to acknowledge events and writes the enable word directly. A single 32-bit register port serves both words: `reg_addr` = 0 selects status and `reg_addr` = 1 selects enable. Reads are combinational on `reg_addr`.

The status word has two 16-bit lanes. Bits 31..16 hold transmit events and bits 15..0 hold receive events. In each lane, position 0 of the lane (bit 16 for transmit, bit 0 for receive) is a summary bit that the hardware computes. Lane positions 1, 2 and 3 are the three summary sources: completion or good frame, descriptor unavailable, and bus error. The remaining lane positions 4..15 latch events but never reach the summary. A lane's interrupt line is its summary bit gated by the enable bit at the summary position. The summary bits and interrupt lines are registered.

Top module: `mac_irq_agg`

## Requirements
- R1: After the asynchronous reset, the status word and the enable word both read 0, and `tx_irq` and `rx_irq` are low.
- R2: A pulse on event lane position k (1..15) sets status bit k (receive) or 16+k (transmit) at the next clock edge. The bit stays set until software clears it or a soft reset occurs.
- R3: A write to the status word (addr 0) clears every status bit whose written bit is 1 and leaves every bit whose written bit is 0 unchanged.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 16 (transmit summary) is 1 exactly when (status & enable) has any of bits 17, 18 or 19 set. It reflects the status and enable of the previous cycle.
- R6: Status bit 0 (receive summary) is 1 exactly when (status & enable) has any of bits 1, 2 or 3 set. It reflects the status and enable of the previous cycle.
- R7: Status bits 4..15 and 20..31 never make a summary bit 1, even when they are set and enabled.
- R8: `tx_irq` equals transmit summary AND enable bit 16, and `rx_irq` equals receive summary AND enable bit 0. Both lines update on the same edge as their summary bit, two edges after the event that causes them.
- R9: A write to the enable word (addr 1), or a clear of a source status bit, changes the summary bits and interrupt lines one edge after the register changes.
- R10: With `soft_rst` high at a clock edge, status, enable, both summary bits and both interrupt lines are 0 after that edge. This holds even when events arrive in the same cycle.
- R11: Event pulses at the summary positions (lane position 0) have no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of status, enable and interrupt lines |
| tx_evt | input | 16 | Transmit event pulses, lane position k maps to status bit 16+k |
| rx_evt | input | 16 | Receive event pulses, lane position k maps to status bit k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 32 | Write data: clear mask for status, new value for enable |
| reg_rdata | output | 32 | Read data of the selected word |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
A wrong status bit shows at `reg_rdata` one edge after the event or write that caused it. A wrong summary or a wrong gating shows at the summary bit and the interrupt lines one edge later. The bench therefore samples two edges after each stimulus, and it probes the intermediate edge to pin down the one-cycle summary latency. If a set/clear collision resolves the wrong way, the event disappears from the status word. If soft reset is ordered wrongly against events, a stale bit survives the reset.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned HALF_W   = WORD_W / 2;
  localparam int unsigned SUM_POS  = 0;
  // lane positions 1..3 feed the summary: done/good, desc unavailable, bus error
  localparam logic [HALF_W-1:0] SRC_MASK = 16'h000E;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_EN   = 1'b1;

  typedef enum logic {
    LANE_RX = 1'b0,
    LANE_TX = 1'b1
  } lane_e;
endpackage

// File: rtl/mac_irq_lane.sv
module mac_irq_lane #(
  parameter int unsigned W        = 16,
  parameter int unsigned SUM_POS  = 0,
  parameter logic [W-1:0] SRC     = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  localparam logic [W-1:0] SUM_ONE = W'(1) << SUM_POS;
  localparam logic [W-1:0] EVT_OK  = ~SUM_ONE;

  logic [W-1:0] stat_q, stat_d;
  logic         stat_ld;
  logic [W-1:0] en_q, en_d;
  logic         en_ld;
  logic         sum_q, sum_d;
  logic         irq_q, irq_d;
  logic [W-1:0] evt_ok;

  assign evt_ok = evt_i & EVT_OK;

  // status next state: clear first, then set, soft reset overrides all
  always_comb begin
    stat_ld = soft_rst | clr_we_i | (|evt_ok);
    stat_d  = stat_q;
    if (clr_we_i) begin
      stat_d = stat_d & ~clr_mask_i;
    end
    stat_d = stat_d | evt_ok;
    if (soft_rst) begin
      stat_d = '0;
    end
  end

  always_comb begin
    en_ld = soft_rst | en_we_i;
    en_d  = soft_rst ? '0 : en_wdata_i;
  end

  always_comb begin
    sum_d = ~soft_rst & (|(stat_q & en_q & SRC));
    irq_d = sum_d & en_q[SUM_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      sum_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_ld) begin
        stat_q <= stat_d;
      end
      if (en_ld) begin
        en_q <= en_d;
      end
      sum_q <= sum_d;
      irq_q <= irq_d;
    end
  end

  assign stat_o = stat_q | (sum_q ? SUM_ONE : '0);
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/mac_irq_regif.sv
module mac_irq_regif #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [WORD_W-1:0] stat_word,
  input  logic [WORD_W-1:0] en_word,
  output logic              stat_clr_we,
  output logic              en_we,
  output logic [WORD_W-1:0] reg_rdata
);
  import mac_irq_pkg::*;

  always_comb begin
    stat_clr_we = reg_we & (reg_addr == ADDR_STAT);
    en_we       = reg_we & (reg_addr == ADDR_EN);
    reg_rdata   = (reg_addr == ADDR_EN) ? en_word : stat_word;
  end
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg #(
  parameter int unsigned WORD_W = mac_irq_pkg::WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  soft_rst,
  input  logic [WORD_W/2-1:0]   tx_evt,
  input  logic [WORD_W/2-1:0]   rx_evt,
  input  logic                  reg_we,
  input  logic                  reg_addr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  tx_irq,
  output logic                  rx_irq
);
  import mac_irq_pkg::*;

  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned NLANE  = 2;

  logic [NLANE-1:0][HALF_W-1:0] evt_lane;
  logic [NLANE-1:0][HALF_W-1:0] stat_lane;
  logic [NLANE-1:0][HALF_W-1:0] en_lane;
  logic [NLANE-1:0][HALF_W-1:0] wdata_lane;
  logic [NLANE-1:0]             irq_lane;
  logic [WORD_W-1:0]            stat_word;
  logic [WORD_W-1:0]            en_word;
  logic                         stat_clr_we;
  logic                         en_we;

  assign evt_lane[LANE_RX] = rx_evt;
  assign evt_lane[LANE_TX] = tx_evt;
  assign wdata_lane        = reg_wdata;
  assign stat_word         = stat_lane;
  assign en_word           = en_lane;

  mac_irq_regif #(.WORD_W(WORD_W)) u_regif (
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .stat_word   (stat_word),
    .en_word     (en_word),
    .stat_clr_we (stat_clr_we),
    .en_we       (en_we),
    .reg_rdata   (reg_rdata)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    mac_irq_lane #(
      .W       (HALF_W),
      .SUM_POS (SUM_POS),
      .SRC     (SRC_MASK)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .evt_i      (evt_lane[g]),
      .clr_we_i   (stat_clr_we),
      .clr_mask_i (wdata_lane[g]),
      .en_we_i    (en_we),
      .en_wdata_i (wdata_lane[g]),
      .stat_o     (stat_lane[g]),
      .en_o       (en_lane[g]),
      .irq_o      (irq_lane[g])
    );
  end

  assign tx_irq = irq_lane[LANE_TX];
  assign rx_irq = irq_lane[LANE_RX];
endmodule

// File: rtl/mac_irq_agg_chk.sv
module mac_irq_agg_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [WORD_W/2-1:0] tx_evt,
  input logic [WORD_W/2-1:0] rx_evt,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] stat_word,
  input logic [WORD_W-1:0] en_word,
  input logic              tx_irq,
  input logic              rx_irq
);
  import mac_irq_pkg::*;
  localparam int unsigned HW = WORD_W / 2;
  localparam logic [WORD_W-1:0] SUM_BITS = (WORD_W'(1) << HW) | WORD_W'(1);
  localparam logic [WORD_W-1:0] TX_SRC   = {SRC_MASK, {HW{1'b0}}};
  localparam logic [WORD_W-1:0] RX_SRC   = {{HW{1'b0}}, SRC_MASK};

  logic [WORD_W-1:0] evt_all;
  logic [WORD_W-1:0] clr_only;
  logic [WORD_W-1:0] collide;
  logic              stat_wr;

  assign evt_all  = {tx_evt, rx_evt} & ~SUM_BITS;
  assign stat_wr  = reg_we && (reg_addr == ADDR_STAT);
  assign clr_only = reg_wdata & ~evt_all & ~SUM_BITS;
  assign collide  = evt_all & reg_wdata;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((stat_word & $past(evt_all)) == $past(evt_all)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !soft_rst) |=> ((stat_word & $past(clr_only)) == '0));

  p_setwins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !soft_rst && (|collide)) |=> ((stat_word & $past(collide)) == $past(collide)));

  p_txsum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (stat_word[HW] == $past(|(stat_word & en_word & TX_SRC))));

  p_rxsum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (stat_word[0] == $past(|(stat_word & en_word & RX_SRC))));

  p_txirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> stat_word[HW]);

  p_rxirq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> stat_word[0]);

  p_soft_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_word == '0 && en_word == '0 && !tx_irq && !rx_irq));
endmodule

bind mac_irq_agg mac_irq_agg_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .tx_evt    (tx_evt),
  .rx_evt    (rx_evt),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .stat_word (stat_word),
  .en_word   (en_word),
  .tx_irq    (tx_irq),
  .rx_irq    (rx_irq)
);

// File: tb/sim_mac_irq_agg.sv
module sim_mac_irq_agg;
  localparam int VW = 136;
  localparam int NV = 12;
  // {req[3:0], evt[31:0], we, addr, wdata[31:0], exp_stat[31:0], exp_en[31:0], exp_tx, exp_rx}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  32'h0002_0002, 1'b0, 1'b0, 32'h0000_0000, 32'h0002_0002, 32'h0000_0000, 1'b0, 1'b0}, // R2
    {4'd5,  32'h0000_0000, 1'b1, 1'b1, 32'h0002_0002, 32'h0003_0003, 32'h0002_0002, 1'b0, 1'b0}, // R5 R6
    {4'd8,  32'h0000_0000, 1'b1, 1'b1, 32'h0003_0003, 32'h0003_0003, 32'h0003_0003, 1'b1, 1'b1}, // R8
    {4'd2,  32'h0100_0100, 1'b1, 1'b1, 32'h0103_0103, 32'h0103_0103, 32'h0103_0103, 1'b1, 1'b1}, // R2
    {4'd7,  32'h0000_0000, 1'b1, 1'b0, 32'h0002_0002, 32'h0100_0100, 32'h0103_0103, 1'b0, 1'b0}, // R3 R7
    {4'd4,  32'h0008_0000, 1'b1, 1'b0, 32'h0008_0000, 32'h0108_0100, 32'h0103_0103, 1'b0, 1'b0}, // R4
    {4'd9,  32'h0000_0000, 1'b1, 1'b1, 32'h010B_0103, 32'h0109_0100, 32'h010B_0103, 1'b1, 1'b0}, // R9
    {4'd2,  32'h0004_0004, 1'b0, 1'b0, 32'h0000_0000, 32'h010D_0104, 32'h010B_0103, 1'b1, 1'b0}, // R2
    {4'd11, 32'h0001_0001, 1'b0, 1'b0, 32'h0000_0000, 32'h010D_0104, 32'h010B_0103, 1'b1, 1'b0}, // R11
    {4'd9,  32'h0000_0000, 1'b1, 1'b1, 32'h0000_0001, 32'h010C_0104, 32'h0000_0001, 1'b0, 1'b0}, // R9
    {4'd8,  32'h0000_0000, 1'b1, 1'b1, 32'h0004_0005, 32'h010D_0105, 32'h0004_0005, 1'b0, 1'b1}, // R8
    {4'd3,  32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0004_0005, 1'b0, 1'b0}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [15:0] tx_evt = '0;
  logic [15:0] rx_evt = '0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_irq;
  logic        rx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mac_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .tx_evt(tx_evt), .rx_evt(rx_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_all(input string tag, input logic [31:0] es, input logic [31:0] ee,
                           input logic et, input logic er);
    logic [31:0] v;
    rd(1'b0, v); chk({tag, " status"}, v, es);
    rd(1'b1, v); chk({tag, " enable"}, v, ee);
    chk({tag, " tx_irq"}, {31'd0, tx_irq}, {31'd0, et});
    chk({tag, " rx_irq"}, {31'd0, rx_irq}, {31'd0, er});
  endtask

  // drive for one cycle, leaves the bench at the negedge after the first edge
  task automatic drive1(input logic [31:0] evt, input logic we, input logic a,
                        input logic [31:0] wd, input logic sr);
    @(negedge clk);
    tx_evt = evt[31:16]; rx_evt = evt[15:0];
    reg_we = we; reg_addr = a; reg_wdata = wd; soft_rst = sr;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; reg_we = 1'b0; reg_wdata = '0; soft_rst = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset", 32'h0, 32'h0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      string tag;
      e = VEC[i];
      drive1(e[131:100], e[99], e[98], e[97:66], 1'b0);
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", e[135:132], i);
      check_all(tag, e[65:34], e[33:2], e[1], e[0]);
    end

    // R5 R8 latency: tx summary and irq lag the status bit by one edge
    drive1(32'h0, 1'b1, 1'b1, 32'h0003_0000, 1'b0);
    @(negedge clk);
    drive1(32'h0002_0000, 1'b0, 1'b0, 32'h0, 1'b0);
    rd(1'b0, v); chk("R5 status before summary", v, 32'h0002_0000);
    chk("R8 tx_irq one edge after event", {31'd0, tx_irq}, 32'd0);
    @(negedge clk);
    rd(1'b0, v); chk("R5 status with summary", v, 32'h0003_0000);
    chk("R8 tx_irq two edges after event", {31'd0, tx_irq}, 32'd1);

    // R9 clearing the source drops the irq one edge later
    drive1(32'h0, 1'b1, 1'b0, 32'h0002_0000, 1'b0);
    chk("R9 tx_irq held one edge after clear", {31'd0, tx_irq}, 32'd1);
    @(negedge clk);
    chk("R9 tx_irq low after clear", {31'd0, tx_irq}, 32'd0);
    rd(1'b0, v); chk("R9 status after clear", v, 32'h0);

    // R6 rx side latency with enable written after event
    drive1(32'h0000_0008, 1'b0, 1'b0, 32'h0, 1'b0);
    drive1(32'h0, 1'b1, 1'b1, 32'h0003_0009, 1'b0);
    chk("R6 rx_irq one edge after enable", {31'd0, rx_irq}, 32'd0);
    @(negedge clk);
    chk("R6 rx_irq after enable", {31'd0, rx_irq}, 32'd1);

    // R10 soft reset wins over a simultaneous event
    drive1(32'h0002_0000, 1'b0, 1'b0, 32'h0, 1'b0);
    @(negedge clk);
    chk("R10 tx_irq before soft reset", {31'd0, tx_irq}, 32'd1);
    drive1(32'h0004_0004, 1'b0, 1'b0, 32'h0, 1'b1);
    check_all("R10 soft reset", 32'h0, 32'h0, 1'b0, 1'b0);

    done = 1'b1;
    report();
  end
endmodule